// File: doc/BRIEF.md
# Serial-Programmed Word Store Sequencer

This block receives command frames over a two-wire serial link (a serial clock and a data line) and applies them to a small non-volatile word store. It holds 8 words of 32 bits by default. A frame names one operation, one word address and one 32-bit data word. The block then either erases the word, clears bits in it, or erases it and stores a new value, all within a single access.

Real storage cells are not modelled. The array is a plain memory. A cycle counter stands in for programming time: after every accepted operation, the `busy` output stays high for a programmable number of system clock cycles. In a real part that number would cover a lockout of at least 20 ms. While `busy` is high, any frame that starts is dropped. After reset the block first fills every word with ones, and `busy` is high while it does so.

The serial inputs are brought into the system clock domain and sampled on each falling edge of the serial clock. A separate read port lets surrounding logic observe the stored words.

Top module: `nvs_frame_seq`

## Requirements
- R1: After reset is released, `busy` is high for about WORDS cycles while every word is set to 32'hFFFFFFFF. `busy` then drops low.
- R2: The data line is sampled on each falling edge of `ser_clk`, which idles high. A frame is made of the following bits, in this order:
  - a start bit of value 1;
  - the command, 4 bits, most significant bit first;
  - the word address, 3 bits, most significant bit first;
  - the data, 32 bits, most significant bit first.
- R3: Command 4'b0100 (erase then write) leaves the addressed word equal to the frame's data exactly.
- R4: Command 4'b0110 (erase only) sets the addressed word to 32'hFFFFFFFF.
- R5: Command 4'b0101 (write only) leaves the addressed word equal to its old value ANDed with the frame's data.
- R6: Any other command value leaves every word unchanged, and `busy` stays low.
- R7: After a supported frame, `busy` rises within a few cycles of the last data bit. It then stays high for between LOCK_CYCLES and LOCK_CYCLES+4 system cycles.
- R8: A frame whose start bit is sampled while `busy` is high is discarded. The array is unchanged, and no new busy period follows.
- R9: The first falling edge after the last data bit is a gap bit and is ignored whatever its level, so it can never act as a start bit.
- R10: `rd_data` shows the word at `rd_addr` one clock later.
- R11: Zeros sampled while idle are not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, idles high |
| ser_dat | input | 1 | Serial data, sampled on falling edges of ser_clk |
| rd_addr | input | ADDR_W | Observation read address |
| rd_data | output | WORD_W | Word at rd_addr, one cycle latency |
| busy | output | 1 | High during the initial fill and during each programming lockout |

## Verification
The bench checks the three supported commands on every address, with data patterns derived from the address.
- Erase-then-write over a dirty word tells an exact store apart from an AND.
- Write-only over a word with known contents tells an AND apart from an overwrite.

All sixteen command codes are sent. This separates the three accepted ones from the thirteen that must be refused without starting a lockout. These refused frames are sent back to back with a gap bit of 1, so a gap taken as a start bit would misalign the next frame. A frame sent during a lockout, and idle clocks with the data line low, show whether refusal and start detection depend on `busy` and on the start bit's level.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_ERASE_WRITE = 4'b0100;
  localparam logic [CMD_W-1:0] CMD_ERASE       = 4'b0110;
  localparam logic [CMD_W-1:0] CMD_WRITE       = 4'b0101;

  typedef enum logic [1:0] {RX_IDLE, RX_SHIFT, RX_GAP} rx_state_e;

  typedef enum logic [2:0] {PC_INIT, PC_IDLE, PC_READ, PC_WRITE, PC_LOCK} pc_state_e;

  function automatic logic cmd_supported(input logic [CMD_W-1:0] c);
    return (c == CMD_ERASE_WRITE) || (c == CMD_ERASE) || (c == CMD_WRITE);
  endfunction

endpackage

// File: rtl/nvs_edge_sync.sv
module nvs_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_dat,
  output logic fall,
  output logic dat
);
  logic c0, c1, c1_d, d0, d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      c0   <= 1'b1;
      c1   <= 1'b1;
      c1_d <= 1'b1;
      d0   <= 1'b0;
      d1   <= 1'b0;
      fall <= 1'b0;
      dat  <= 1'b0;
    end else begin
      c0   <= ser_clk;
      c1   <= c0;
      c1_d <= c1;
      d0   <= ser_dat;
      d1   <= d0;
      fall <= c1_d & ~c1;
      dat  <= d1;
    end
  end

  // R2: one sample strobe per serial clock fall
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);

endmodule

// File: rtl/nvs_frame_rx.sv
module nvs_frame_rx
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              dat,
  input  logic              busy,
  output logic              frm_vld,
  output logic [CMD_W-1:0]  frm_cmd,
  output logic [ADDR_W-1:0] frm_addr,
  output logic [WORD_W-1:0] frm_data
);
  localparam int FRAME_BITS = CMD_W + ADDR_W + WORD_W;
  localparam int CW         = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  rx_state_e             state;
  logic [CW-1:0]         cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  refused;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      refused <= 1'b0;
      frm_vld <= 1'b0;
    end else begin
      frm_vld <= 1'b0;
      if (fall) begin
        unique case (state)
          RX_IDLE: begin
            if (dat) begin
              state   <= RX_SHIFT;
              cnt     <= '0;
              refused <= busy;
            end
          end
          RX_SHIFT: begin
            shreg <= {shreg[FRAME_BITS-2:0], dat};
            if (cnt == LAST) begin
              state   <= RX_GAP;
              frm_vld <= !(refused || busy);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign frm_cmd  = shreg[FRAME_BITS-1 -: CMD_W];
  assign frm_addr = shreg[WORD_W +: ADDR_W];
  assign frm_data = shreg[WORD_W-1:0];

  // R9: the bit after the data field never starts a frame
  a_r9_gap_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == RX_GAP && fall) |=> state == RX_IDLE);

  // R2: a completed frame comes from a sampled falling edge
  a_r2_vld_on_edge: assert property (@(posedge clk) disable iff (rst)
    frm_vld |-> $past(fall));

endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [WORD_W-1:0] b_rdata
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/nvs_prog_ctrl.sv
module nvs_prog_ctrl
  import nvs_pkg::*;
#(
  parameter int WORDS       = 8,
  parameter int WORD_W      = 32,
  parameter int LOCK_CYCLES = 1000000,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_vld,
  input  logic [CMD_W-1:0]  frm_cmd,
  input  logic [ADDR_W-1:0] frm_addr,
  input  logic [WORD_W-1:0] frm_data,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_we,
  output logic [WORD_W-1:0] m_wdata,
  input  logic [WORD_W-1:0] m_rdata,
  output logic              busy
);
  localparam int LCW = $clog2(LOCK_CYCLES + 1);
  localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(WORDS - 1);

  pc_state_e         state, state_n;
  logic [ADDR_W-1:0] init_idx;
  logic [CMD_W-1:0]  op_cmd;
  logic [ADDR_W-1:0] op_addr;
  logic [WORD_W-1:0] op_data;
  logic [LCW-1:0]    lock_cnt;

  always_comb begin
    state_n = state;
    unique case (state)
      PC_INIT:  if (init_idx == LAST_WORD) state_n = PC_IDLE;
      PC_IDLE:  if (frm_vld && cmd_supported(frm_cmd)) state_n = PC_READ;
      PC_READ:  state_n = PC_WRITE;
      PC_WRITE: state_n = PC_LOCK;
      PC_LOCK:  if (lock_cnt == '0) state_n = PC_IDLE;
      default:  state_n = PC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PC_INIT;
      init_idx <= '0;
      op_cmd   <= '0;
      op_addr  <= '0;
      op_data  <= '0;
      lock_cnt <= '0;
      busy     <= 1'b1;
    end else begin
      state <= state_n;
      busy  <= (state_n != PC_IDLE);
      if (state == PC_INIT) init_idx <= init_idx + 1'b1;
      if (state == PC_IDLE && frm_vld) begin
        op_cmd  <= frm_cmd;
        op_addr <= frm_addr;
        op_data <= frm_data;
      end
      if (state == PC_WRITE) lock_cnt <= LCW'(LOCK_CYCLES - 1);
      else if (state == PC_LOCK && lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
    end
  end

  always_comb begin
    m_addr  = (state == PC_INIT) ? init_idx : op_addr;
    m_we    = (state == PC_INIT) || (state == PC_WRITE);
    m_wdata = '1;
    if (state == PC_WRITE) begin
      unique case (op_cmd)
        CMD_ERASE_WRITE: m_wdata = op_data;
        CMD_WRITE:       m_wdata = m_rdata & op_data;
        default:         m_wdata = '1;
      endcase
    end
  end

  // R7: busy held through the whole lockout count
  a_r7_lock_holds_busy: assert property (@(posedge clk) disable iff (rst)
    (state == PC_LOCK && lock_cnt != '0) |=> busy);

  // R6: an unsupported command does not leave idle
  a_r6_reject_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (state == PC_IDLE && frm_vld && !cmd_supported(frm_cmd)) |=> state == PC_IDLE);

  // R1: busy during the initial fill
  a_r1_init_busy: assert property (@(posedge clk) disable iff (rst)
    (state == PC_INIT) |-> busy);

endmodule

// File: rtl/nvs_frame_seq.sv
module nvs_frame_seq
  import nvs_pkg::*;
#(
  parameter int WORDS       = 8,
  parameter int WORD_W      = 32,
  parameter int LOCK_CYCLES = 1000000,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy
);
  logic              fall, dat, frm_vld, m_we;
  logic [CMD_W-1:0]  frm_cmd;
  logic [ADDR_W-1:0] frm_addr, m_addr;
  logic [WORD_W-1:0] frm_data, m_wdata, m_rdata;

  nvs_edge_sync u_sync (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .fall(fall), .dat(dat)
  );

  nvs_frame_rx #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .fall(fall), .dat(dat), .busy(busy),
    .frm_vld(frm_vld), .frm_cmd(frm_cmd), .frm_addr(frm_addr), .frm_data(frm_data)
  );

  nvs_prog_ctrl #(.WORDS(WORDS), .WORD_W(WORD_W), .LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_cmd(frm_cmd),
    .frm_addr(frm_addr), .frm_data(frm_data), .m_addr(m_addr), .m_we(m_we),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .busy(busy)
  );

  nvs_array #(.WORDS(WORDS), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .a_addr(m_addr), .a_we(m_we), .a_wdata(m_wdata), .a_rdata(m_rdata),
    .b_addr(rd_addr), .b_rdata(rd_data)
  );

  // R7: an accepted frame raises busy on the next cycle
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && cmd_supported(frm_cmd)) |=> busy);

  // R8: the store is written only inside a busy period
  a_r8_write_only_busy: assert property (@(posedge clk) disable iff (rst)
    m_we |-> busy);

endmodule

// File: tb/nvs_frame_seq_test.sv
`timescale 1ns/1ps
module nvs_frame_seq_test;
  localparam int WORDS = 8;
  localparam int LOCK  = 200;
  localparam int HALF  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b1;
  logic        ser_dat = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [WORDS];
  int run = 0;
  int last_run = 0;

  nvs_frame_seq #(.WORDS(WORDS), .WORD_W(32), .LOCK_CYCLES(LOCK)) uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst) run = 0;
    else if (busy) run = run + 1;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_clk(HALF);
    ser_clk = 1'b0;
    wait_clk(HALF);
    ser_clk = 1'b1;
  endtask

  task automatic send_frame(input logic [3:0] c, input logic [2:0] a, input logic [31:0] d, input logic gap);
    send_bit(1'b1);
    for (int i = 3; i >= 0; i--) send_bit(c[i]);
    for (int i = 2; i >= 0; i--) send_bit(a[i]);
    for (int i = 31; i >= 0; i--) send_bit(d[i]);
    send_bit(gap);
    ser_dat = 1'b0;
    wait_clk(4);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * LOCK && busy; i++) @(negedge clk);
    wait_clk(2);
  endtask

  task automatic read_word(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int a = 0; a < WORDS; a++) begin
      read_word(3'(a), d);
      check(d === model[a], tag, d, model[a]);
    end
  endtask

  function automatic bit supported(input logic [3:0] c);
    return c == 4'b0100 || c == 4'b0110 || c == 4'b0101;
  endfunction

  initial begin
    wait_clk(150000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    wait_clk(3);
    check(busy === 1'b1, "R1 busy in reset", 32'(busy), 32'h1);
    rst = 1'b0;
    wait_clk(WORDS + 6);
    check(busy === 1'b0, "R1 busy after fill", 32'(busy), 32'h0);
    check(last_run >= WORDS - 1 && last_run <= WORDS + 2, "R1 fill length", 32'(last_run), 32'(WORDS));
    for (int a = 0; a < WORDS; a++) model[a] = 32'hFFFF_FFFF;
    check_all("R1 R10 initial ones");

    // R11: idle clocks with data low
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    check(busy === 1'b0, "R11 no start on zero", 32'(busy), 32'h0);

    // R3: erase-then-write on every address
    for (int a = 0; a < WORDS; a++) begin
      d = 32'h5A3C_0F00 ^ (32'(a) * 32'h0101_0101) ^ (32'(a) << 28);
      send_frame(4'b0100, 3'(a), d, 1'b0);
      check(busy === 1'b1, "R7 busy after frame", 32'(busy), 32'h1);
      wait_idle();
      check(last_run >= LOCK && last_run <= LOCK + 4, "R7 lock length", 32'(last_run), 32'(LOCK));
      model[a] = d;
    end
    check_all("R3 erase-write");

    // R3: exact store over a dirty word (not an AND)
    send_frame(4'b0100, 3'd2, 32'hFFFF_0000 | model[2], 1'b0);
    wait_idle();
    model[2] = 32'hFFFF_0000 | model[2];
    check_all("R3 overwrite");

    // R5: write-only clears bits
    for (int a = 0; a < WORDS; a++) begin
      d = ~(32'hF << (4 * a)) & ~(32'(a) + 32'h10);
      send_frame(4'b0101, 3'(a), d, 1'b0);
      wait_idle();
      model[a] = model[a] & d;
    end
    check_all("R5 write-and");

    // R4: erase odd words
    for (int a = 1; a < WORDS; a += 2) begin
      send_frame(4'b0110, 3'(a), 32'h0, 1'b0);
      wait_idle();
      model[a] = 32'hFFFF_FFFF;
    end
    check_all("R4 erase");

    // R5: write-only on an erased word stores data
    send_frame(4'b0101, 3'd3, 32'h1234_5678, 1'b0);
    wait_idle();
    model[3] = 32'h1234_5678;
    check_all("R5 write on erased");

    // R6 R9: unsupported codes back to back, gap bit 1
    for (int c = 0; c < 16; c++) begin
      if (!supported(4'(c))) begin
        send_frame(4'(c), 3'(c % WORDS), 32'h0, 1'b1);
        check(busy === 1'b0, "R6 no lockout", 32'(busy), 32'h0);
      end
    end
    check_all("R6 unchanged");
    send_frame(4'b0100, 3'd0, 32'hCAFE_F00D, 1'b1);
    wait_idle();
    model[0] = 32'hCAFE_F00D;
    check_all("R9 aligned after gap 1");

    // R8: frame started during lockout
    send_frame(4'b0100, 3'd4, 32'h0BAD_BEEF, 1'b0);
    model[4] = 32'h0BAD_BEEF;
    check(busy === 1'b1, "R8 busy before second", 32'(busy), 32'h1);
    send_frame(4'b0100, 3'd5, 32'h0000_0000, 1'b0);
    wait_clk(LOCK);
    check(busy === 1'b0, "R8 no new lockout", 32'(busy), 32'h0);
    check_all("R8 discarded");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule